// File: doc/BRIEF.md
# Interrupt Moderation Timer

This block sits between interrupt request strobes and the interrupt lines and limits how often each line may fire. One shared prescaler divides a free-running base tick by a programmable resolution value N, producing a unit tick every N+1 base ticks. Each channel owns an 8-bit down-counter measured in those units. When a channel delivers an interrupt, its counter is loaded with that channel's interval. Requests that arrive while the counter runs are held and merged. When the counter runs out, or a flush strobe arrives, the held request is released as a single one-cycle pulse.

Each channel is a three-state machine:
- `CH_IDLE`: the counter is zero and nothing is held. A request fires on the next edge and moves the channel to `CH_COUNT`, or keeps it in `CH_IDLE` when the interval is zero.
- `CH_COUNT`: the counter is running and nothing is held. A request moves it to `CH_HELD`. The last unit tick returns it to `CH_IDLE`. An interval of zero returns it to `CH_IDLE` with the counter cleared.
- `CH_HELD`: a request is waiting. The last unit tick, a flush or an interval of zero fires the channel and reloads it into `CH_COUNT` (or `CH_IDLE` when the interval is zero).

A request that meets the firing condition in `CH_COUNT` fires directly from there.

Instances serve both per-group and per-vector lines. Every channel has its own interval, and all channels share the one resolution setting.

Top module: `irq_moderator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every irq_pulse bit is 0 and every channel is in `CH_IDLE`, so the first request after reset fires on the next cycle.
- R2: The unit tick advances only on cycles where base_tick is 1. While base_tick stays 0, a held request is never released by the timer.
- R3: With a resolution N, an interval I > 0, base_tick high every cycle and a request present every cycle, consecutive pulses after the first expiry are spaced exactly I*(N+1) clock cycles apart.
- R4: An interval value of 0 bypasses moderation: every cycle with a request yields a pulse on the following cycle. A request held when the interval becomes 0 is released on the next cycle.
- R5: A request reaching a channel in `CH_IDLE` produces irq_pulse high on the cycle after the request edge, for exactly one cycle when the interval is nonzero and no second firing cause exists.
- R6: Requests arriving while the counter is nonzero produce no pulse before a release cause. Any number of them merge into a single pulse.
- R7: A mod_flush strobe releases a held request, or one arriving in the same cycle, as a pulse on the next cycle. A flush with nothing held produces no pulse.
- R8: Any change of res_val restarts the prescaler from zero. After a change seen at edge E, the first unit tick falls on edge E+N+1.
- R9: Intervals are independent per channel, while the resolution is shared by all channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Free-running base tick enable |
| res_val | input | RES_W | Resolution N; the unit tick occurs every N+1 base ticks |
| ivl_val | input | NUM_CH*IVL_W | Per-channel interval in units; channel i occupies bits [i*IVL_W +: IVL_W] |
| req_pend | input | NUM_CH | Per-channel request strobe, one request per high cycle |
| mod_flush | input | 1 | Releases every held request at once |
| irq_pulse | output | NUM_CH | Per-channel moderated interrupt pulse |

## Verification
The bench builds the block with NUM_CH=2, RES_W=4 and IVL_W=8. A 4-bit resolution keeps a full prescaler period at 16 cycles, so spacing rows up to I*(N+1)=200 complete quickly. The full 8-bit interval still reaches the large-count paths. Two channels are enough to show one channel bypassing while the other is held, both on the shared resolution.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_HELD  = 2'd2
    } ch_state_t;

endpackage

// File: rtl/irqm_prescaler.sv
module irqm_prescaler #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic [RES_W-1:0] res_val,
    output logic             unit_tick
);

    logic [RES_W-1:0] div_q;
    logic [RES_W-1:0] res_q;
    logic             res_chg;

    assign res_chg   = (res_val != res_q);
    assign unit_tick = base_tick && !res_chg && (div_q == res_q);

    // Divider count: restarts from zero on any resolution change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            res_q <= '0;
        end else if (res_chg) begin
            div_q <= '0;
            res_q <= res_val;
        end else if (base_tick) begin
            div_q <= unit_tick ? '0 : div_q + 1'b1;
        end
    end

endmodule

// File: rtl/irqm_channel.sv
module irqm_channel
    import irqm_pkg::*;
#(
    parameter int IVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_tick,
    input  logic [IVL_W-1:0] ivl_val,
    input  logic             req,
    input  logic             flush,
    output logic             irq
);

    localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

    ch_state_t        state_q, state_d;
    logic [IVL_W-1:0] cnt_q, cnt_d;
    logic             fire;
    logic             bypass;
    logic             last_unit;
    logic             irq_q;

    assign bypass    = (ivl_val == '0);
    assign last_unit = unit_tick && (cnt_q == ONE);

    // Next-state and counter decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (req) fire = 1'b1;
            end
            CH_COUNT: begin
                if (req && (last_unit || flush || bypass)) begin
                    fire = 1'b1;
                end else if (bypass) begin
                    state_d = CH_IDLE;
                    cnt_d   = '0;
                end else begin
                    if (unit_tick) cnt_d = cnt_q - 1'b1;
                    if (req)            state_d = CH_HELD;
                    else if (last_unit) state_d = CH_IDLE;
                end
            end
            CH_HELD: begin
                if (last_unit || flush || bypass) fire = 1'b1;
                else if (unit_tick)               cnt_d = cnt_q - 1'b1;
            end
            default: begin
                state_d = CH_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (fire) begin
            cnt_d   = ivl_val;
            state_d = bypass ? CH_IDLE : CH_COUNT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fire;
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 8,
    parameter int IVL_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    base_tick,
    input  logic [RES_W-1:0]        res_val,
    input  logic [NUM_CH*IVL_W-1:0] ivl_val,
    input  logic [NUM_CH-1:0]       req_pend,
    input  logic                    mod_flush,
    output logic [NUM_CH-1:0]       irq_pulse
);

    logic unit_tick;

    irqm_prescaler #(.RES_W(RES_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .res_val   (res_val),
        .unit_tick (unit_tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        irqm_channel #(.IVL_W(IVL_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .unit_tick (unit_tick),
            .ivl_val   (ivl_val[i*IVL_W +: IVL_W]),
            .req       (req_pend[i]),
            .flush     (mod_flush),
            .irq       (irq_pulse[i])
        );
    end

endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 8,
    parameter int IVL_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    base_tick,
    input logic [RES_W-1:0]        res_val,
    input logic [NUM_CH*IVL_W-1:0] ivl_val,
    input logic [NUM_CH-1:0]       req_pend,
    input logic                    mod_flush,
    input logic [NUM_CH-1:0]       irq_pulse,
    input logic                    unit_tick
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_pulse == '0));

    p_tick_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        unit_tick |-> base_tick);

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (res_val != $past(res_val))) |-> !unit_tick);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((ivl_val[i*IVL_W +: IVL_W] == '0) && req_pend[i]) |=> irq_pulse[i]);

        p_flush_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mod_flush && req_pend[i]) |=> irq_pulse[i]);

        p_no_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!base_tick && !req_pend[i] && !mod_flush &&
             (ivl_val[i*IVL_W +: IVL_W] != '0)) |=> !irq_pulse[i]);
    end

endmodule

bind irq_moderator irqm_checker #(
    .NUM_CH (NUM_CH),
    .RES_W  (RES_W),
    .IVL_W  (IVL_W)
) u_irqm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .res_val   (res_val),
    .ivl_val   (ivl_val),
    .req_pend  (req_pend),
    .mod_flush (mod_flush),
    .irq_pulse (irq_pulse),
    .unit_tick (unit_tick)
);

// File: tb/irq_moderator_tb_top.sv
`timescale 1ns/1ps
module irq_moderator_tb_top;

    localparam int NUM_CH = 2;
    localparam int RES_W  = 4;
    localparam int IVL_W  = 8;
    localparam int ROWS   = 8;
    localparam int WDOG   = 150000;

    localparam logic [RES_W-1:0] T_RES [ROWS] = '{4'd0, 4'd0, 4'd3, 4'd2, 4'd1, 4'd7, 4'd15, 4'd0};
    localparam logic [IVL_W-1:0] T_IVL [ROWS] = '{8'd1, 8'd5, 8'd2, 8'd4, 8'd0, 8'd3, 8'd10, 8'd200};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    base_tick = 1'b1;
    logic [RES_W-1:0]        res_val = '0;
    logic [IVL_W-1:0]        ivl0 = '0;
    logic [IVL_W-1:0]        ivl1 = '0;
    logic [NUM_CH-1:0]       req_pend = '0;
    logic                    mod_flush = 1'b0;
    logic [NUM_CH-1:0]       irq_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_moderator #(.NUM_CH(NUM_CH), .RES_W(RES_W), .IVL_W(IVL_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .res_val   (res_val),
        .ivl_val   ({ivl1, ivl0}),
        .req_pend  (req_pend),
        .mod_flush (mod_flush),
        .irq_pulse (irq_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        req_pend  = '0;
        mod_flush = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen, k, p2, p3, exp, n0, n1;

        // R1: quiet during and after reset
        repeat (3) @(negedge clk);
        chk(irq_pulse == '0, "R1 in reset", irq_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_pulse == '0, "R1 after reset", irq_pulse, 0);

        // R3 / R4 / R9: pulse spacing table on channel 0
        for (int r = 0; r < ROWS; r++) begin
            res_val = T_RES[r];
            ivl0    = T_IVL[r];
            go_idle();
            req_pend[0] = 1'b1;
            seen = 0; k = 0; p2 = 0; p3 = 0;
            while (seen < 3 && k < 5000) begin
                @(negedge clk);
                k++;
                if (irq_pulse[0]) begin
                    seen++;
                    if (seen == 2) p2 = k;
                    if (seen == 3) p3 = k;
                end
            end
            exp = (T_IVL[r] == 0) ? 1 : int'(T_IVL[r]) * (int'(T_RES[r]) + 1);
            chk(seen == 3 && (p3 - p2) == exp, "R3 spacing", p3 - p2, exp);
            req_pend[0] = 1'b0;
        end

        // R5 / R6 / R7: idle fire, hold and merge, flush
        res_val = '0; ivl0 = 8'd20;
        go_idle();
        req_pend[0] = 1'b1;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R5 idle request fires", irq_pulse[0], 1);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R5 single cycle", irq_pulse[0], 0);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R6 held", irq_pulse[0], 0);
        req_pend[0] = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(irq_pulse[0] == 1'b0, "R6 held quiet", irq_pulse[0], 0);
        end
        mod_flush = 1'b1;
        @(negedge clk);
        mod_flush = 1'b0;
        chk(irq_pulse[0] == 1'b1, "R7 flush releases", irq_pulse[0], 1);
        n0 = 0;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            if (irq_pulse[0]) n0++;
        end
        chk(n0 == 0, "R6 merged into one pulse", n0, 0);
        mod_flush = 1'b1;
        @(negedge clk);
        mod_flush = 1'b0;
        chk(irq_pulse[0] == 1'b0, "R7 empty flush", irq_pulse[0], 0);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R7 empty flush later", irq_pulse[0], 0);

        // R4: held request released when interval drops to zero, then bypass
        ivl0 = 8'd50;
        go_idle();
        req_pend[0] = 1'b1;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R5 fire before hold", irq_pulse[0], 1);
        @(negedge clk);
        req_pend[0] = 1'b0;
        chk(irq_pulse[0] == 1'b0, "R6 hold at 50", irq_pulse[0], 0);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R6 hold at 50 later", irq_pulse[0], 0);
        ivl0 = 8'd0;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R4 release on zero interval", irq_pulse[0], 1);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R4 nothing left", irq_pulse[0], 0);
        req_pend[0] = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(irq_pulse[0] == 1'b1, "R4 bypass every cycle", irq_pulse[0], 1);
        end
        req_pend[0] = 1'b0;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R4 bypass stops", irq_pulse[0], 0);

        // R2: base tick low freezes the timer
        ivl0 = 8'd2;
        go_idle();
        base_tick = 1'b0;
        req_pend[0] = 1'b1;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R2 idle fire without tick", irq_pulse[0], 1);
        n0 = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (irq_pulse[0]) n0++;
        end
        chk(n0 == 0, "R2 frozen while base tick low", n0, 0);
        req_pend[0] = 1'b0;
        base_tick = 1'b1;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b0, "R2 first unit", irq_pulse[0], 0);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R2 expiry after two units", irq_pulse[0], 1);

        // R8: resolution change restarts the prescaler
        res_val = 4'd1; ivl0 = 8'd1;
        go_idle();
        req_pend[0] = 1'b1;
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R8 setup fire", irq_pulse[0], 1);
        res_val = 4'd3;
        @(negedge clk);
        req_pend[0] = 1'b0;
        chk(irq_pulse[0] == 1'b0, "R8 held", irq_pulse[0], 0);
        n0 = 0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            if (irq_pulse[0]) n0++;
        end
        chk(n0 == 0, "R8 no early tick", n0, 0);
        @(negedge clk);
        chk(irq_pulse[0] == 1'b1, "R8 tick at N+1 after change", irq_pulse[0], 1);

        // R9: independent intervals, shared resolution
        res_val = '0; ivl0 = 8'd0; ivl1 = 8'd50;
        go_idle();
        req_pend = 2'b11;
        n0 = 0; n1 = 0;
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (irq_pulse[0]) n0++;
            if (irq_pulse[1]) n1++;
        end
        chk(n0 == 30, "R9 channel 0 bypass count", n0, 30);
        chk(n1 == 1, "R9 channel 1 moderated count", n1, 1);

        // R1: reset mid-hold returns the channel to idle
        rst_n = 1'b0;
        req_pend = '0;
        repeat (3) @(negedge clk);
        chk(irq_pulse == '0, "R1 mid-run reset", irq_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        req_pend[1] = 1'b1;
        @(negedge clk);
        req_pend[1] = 1'b0;
        chk(irq_pulse[1] == 1'b1, "R1 idle after reset", irq_pulse[1], 1);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule